// File: doc/BRIEF.md
# UART FIFO Interrupt Generator

This block sits between a UART's host register interface and its serialiser. It holds a transmit queue and a receive queue of bytes, and it produces three level-sensitive interrupt lines: transmit, receive and modem-status-change. The host writes bytes into the transmit queue and reads bytes from the receive queue. The serialiser pops bytes from the transmit queue and pushes received bytes into the receive queue. A strobe that pulses once per character time drives the receive idle timeout.

A mode input chooses between two behaviours. In queue mode, each side holds 16 bytes and the interrupts follow occupancy thresholds. The receive side also raises its interrupt on a short, stale queue after three idle character times. In holding mode, each side holds a single byte, and the interrupts follow whether that byte is present. Any change of the mode input empties both sides.

The two modem status inputs pass through a synchroniser. Any change of level on either of them sets a sticky interrupt. A dedicated end-of-interrupt pulse clears that interrupt.

Top module: `uart_fifo_irq`

## Requirements
- R1: After reset both sides are empty (`tx_avail_o`=0, `rx_avail_o`=0), `tx_irq_o`=1, `rx_irq_o`=0 and `ms_irq_o`=0.
- R2: In queue mode each side is first-in first-out with 16 entries. A write to a full side is dropped, and the stored bytes and their order are unchanged.
- R3: In queue mode, `tx_irq_o` is 1 exactly while the transmit occupancy is 8 or less.
- R4: In holding mode the transmit side holds one byte. A second write while it is occupied is dropped. `tx_irq_o` is 1 exactly while the transmit side is empty.
- R5: In queue mode, `rx_irq_o` is 1 whenever the receive occupancy is 8 or more.
- R6: In queue mode with a non-empty receive side, three `char_tick_i` pulses with no accepted push and no host read in between set `rx_irq_o`, visible in the cycle after the third pulse. A push or a host read restarts the count. Once set, the interrupt stays until the receive side is read empty.
- R7: In holding mode the receive side holds one byte, and a second push while it is occupied is dropped. `rx_irq_o` is 1 exactly while that byte is present, and character ticks have no effect on it.
- R8: A level change on `cts_i` or `dsr_i` sets `ms_irq_o` on the third rising clock edge after the change. `msi_eoi_i` clears it in the following cycle.
- R9: If a synchronised edge and `msi_eoi_i` fall in the same cycle, `ms_irq_o` remains 1.
- R10: In the cycle after `fifo_en_i` changes value, both sides are empty and the idle timeout is cleared.
- R11: A pop of an empty transmit side and a host read of an empty receive side leave both sides empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fifo_en_i | input | 1 | 1 selects queue mode, 0 selects holding mode |
| host_wr_i | input | 1 | Host write of one byte into the transmit side |
| host_wdata_i | input | 8 | Byte written by the host |
| host_rd_i | input | 1 | Host read that removes the receive head |
| host_rdata_o | output | 8 | Receive head byte, valid while `rx_avail_o` is 1 |
| rx_avail_o | output | 1 | Receive side is non-empty |
| tx_pop_i | input | 1 | Serialiser takes the transmit head |
| tx_data_o | output | 8 | Transmit head byte |
| tx_avail_o | output | 1 | Transmit side is non-empty |
| rx_push_i | input | 1 | Serialiser delivers a received byte |
| rx_data_i | input | 8 | Received byte |
| char_tick_i | input | 1 | One pulse per character time |
| cts_i | input | 1 | Modem clear-to-send line (asynchronous) |
| dsr_i | input | 1 | Modem data-set-ready line (asynchronous) |
| msi_eoi_i | input | 1 | End-of-interrupt pulse for the modem interrupt |
| tx_irq_o | output | 1 | Transmit interrupt |
| rx_irq_o | output | 1 | Receive interrupt |
| ms_irq_o | output | 1 | Modem status change interrupt |

## Verification
A synchronised modem edge and an end-of-interrupt write can land in the same cycle. The two compete for the same sticky bit, and set must win. The bench first sets the interrupt from one line and then toggles the other line. It counts the synchroniser stages to place the end-of-interrupt pulse exactly in the cycle where the new edge is detected, and expects the interrupt still high afterwards. A second clear with no edge pending is then expected to drop it. A similar overlap exists on the receive side, where a host read restarts the idle count in the same cycles that character ticks arrive. The bench issues reads between ticks and expects the timeout to count only from the last read.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int unsigned DATA_W_DEF     = 8;
  localparam int unsigned DEPTH_DEF      = 16;
  localparam int unsigned IDLE_TICKS_DEF = 3;
  localparam int unsigned MODEM_LINES    = 2;
endpackage

// File: rtl/uart_byte_fifo.sv
module uart_byte_fifo #(
  parameter  int unsigned DATA_W = 8,
  parameter  int unsigned DEPTH  = 16,
  localparam int unsigned AW     = $clog2(DEPTH),
  localparam int unsigned CW     = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              single_i,
  input  logic              push_i,
  input  logic [DATA_W-1:0] din_i,
  input  logic              pop_i,
  output logic [DATA_W-1:0] dout_o,
  output logic [CW-1:0]     count_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [AW-1:0]     wp_q, rp_q;
  logic [CW-1:0]     cnt_q;
  logic              full, do_push, do_pop;

  // holding mode caps occupancy at one entry
  assign full    = single_i ? (cnt_q != '0) : (cnt_q == CW'(DEPTH));
  assign do_push = push_i & ~full;
  assign do_pop  = pop_i & (cnt_q != '0);

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else if (flush_i) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wp_q <= nxt(wp_q);
      if (do_pop)  rp_q <= nxt(rp_q);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push && !flush_i) mem_q[wp_q] <= din_i;
  end

  assign dout_o  = mem_q[rp_q];
  assign count_o = cnt_q;
endmodule

// File: rtl/uart_rx_timeout.sv
module uart_rx_timeout #(
  parameter  int unsigned TICKS = 3,
  localparam int unsigned TW    = $clog2(TICKS + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic en_i,
  input  logic empty_i,
  input  logic reload_i,
  input  logic tick_i,
  output logic flag_o
);
  logic [TW-1:0] cnt_q;
  logic          flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else if (clr_i || !en_i || empty_i) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else if (reload_i) begin
      cnt_q  <= '0;
    end else if (tick_i && !flag_q) begin
      if (cnt_q == TW'(TICKS - 1)) begin
        cnt_q  <= '0;
        flag_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/uart_modem_chg.sv
module uart_modem_chg #(
  parameter int unsigned N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] lines_i,
  input  logic         eoi_i,
  output logic [N-1:0] chg_o,
  output logic         irq_o
);
  logic irq_q;

  for (genvar g = 0; g < N; g++) begin : g_line
    logic s1_q, s2_q, prev_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q   <= 1'b0;
        s2_q   <= 1'b0;
        prev_q <= 1'b0;
      end else begin
        s1_q   <= lines_i[g];
        s2_q   <= s1_q;
        prev_q <= s2_q;
      end
    end
    assign chg_o[g] = s2_q ^ prev_q;
  end

  // set wins over end-of-interrupt
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= (|chg_o) | (irq_q & ~eoi_i);
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/uart_fifo_irq.sv
module uart_fifo_irq
  import uart_irq_pkg::*;
#(
  parameter int unsigned DATA_W     = DATA_W_DEF,
  parameter int unsigned DEPTH      = DEPTH_DEF,
  parameter int unsigned IDLE_TICKS = IDLE_TICKS_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fifo_en_i,
  input  logic              host_wr_i,
  input  logic [DATA_W-1:0] host_wdata_i,
  input  logic              host_rd_i,
  output logic [DATA_W-1:0] host_rdata_o,
  output logic              rx_avail_o,
  input  logic              tx_pop_i,
  output logic [DATA_W-1:0] tx_data_o,
  output logic              tx_avail_o,
  input  logic              rx_push_i,
  input  logic [DATA_W-1:0] rx_data_i,
  input  logic              char_tick_i,
  input  logic              cts_i,
  input  logic              dsr_i,
  input  logic              msi_eoi_i,
  output logic              tx_irq_o,
  output logic              rx_irq_o,
  output logic              ms_irq_o
);
  localparam int unsigned CW   = $clog2(DEPTH + 1);
  localparam int unsigned HALF = DEPTH / 2;

  logic                   en_q, mode_flip;
  logic [CW-1:0]          tx_cnt, rx_cnt;
  logic                   to_flag;
  logic [MODEM_LINES-1:0] ms_chg;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= 1'b0;
    else         en_q <= fifo_en_i;
  end
  assign mode_flip = fifo_en_i ^ en_q;

  uart_byte_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) tx_fifo_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .flush_i  (mode_flip),
    .single_i (~fifo_en_i),
    .push_i   (host_wr_i),
    .din_i    (host_wdata_i),
    .pop_i    (tx_pop_i),
    .dout_o   (tx_data_o),
    .count_o  (tx_cnt)
  );

  uart_byte_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) rx_fifo_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .flush_i  (mode_flip),
    .single_i (~fifo_en_i),
    .push_i   (rx_push_i),
    .din_i    (rx_data_i),
    .pop_i    (host_rd_i),
    .dout_o   (host_rdata_o),
    .count_o  (rx_cnt)
  );

  uart_rx_timeout #(.TICKS(IDLE_TICKS)) rx_to_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (mode_flip),
    .en_i     (fifo_en_i),
    .empty_i  (rx_cnt == '0),
    .reload_i (rx_push_i | host_rd_i),
    .tick_i   (char_tick_i),
    .flag_o   (to_flag)
  );

  uart_modem_chg #(.N(MODEM_LINES)) modem_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .lines_i ({dsr_i, cts_i}),
    .eoi_i   (msi_eoi_i),
    .chg_o   (ms_chg),
    .irq_o   (ms_irq_o)
  );

  assign tx_avail_o = (tx_cnt != '0);
  assign rx_avail_o = (rx_cnt != '0);

  assign tx_irq_o = fifo_en_i ? (tx_cnt <= CW'(HALF)) : (tx_cnt == '0);
  assign rx_irq_o = fifo_en_i ? ((rx_cnt >= CW'(HALF)) || (to_flag && rx_cnt != '0))
                              : (rx_cnt != '0);
endmodule

// File: rtl/uart_fifo_irq_chk.sv
module uart_fifo_irq_chk #(
  parameter  int unsigned DEPTH = 16,
  localparam int unsigned CW    = $clog2(DEPTH + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          fifo_en_i,
  input logic          host_wr_i,
  input logic          tx_pop_i,
  input logic          rx_push_i,
  input logic          msi_eoi_i,
  input logic          mode_flip,
  input logic [CW-1:0] tx_cnt,
  input logic [CW-1:0] rx_cnt,
  input logic          to_flag,
  input logic [1:0]    ms_chg,
  input logic          tx_avail_o,
  input logic          rx_avail_o,
  input logic          tx_irq_o,
  input logic          rx_irq_o,
  input logic          ms_irq_o
);
  // R2
  occ_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_cnt <= CW'(DEPTH)) && (rx_cnt <= CW'(DEPTH)));

  // R2
  full_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_en_i && !mode_flip && tx_cnt == CW'(DEPTH) && host_wr_i && !tx_pop_i
    |=> tx_cnt == CW'(DEPTH));

  // R4
  hold_tx_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fifo_en_i && tx_avail_o |-> !tx_irq_o);

  // R6
  idle_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_en_i && !mode_flip && to_flag && rx_cnt > 1 |=> rx_irq_o);

  // R8
  edge_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ms_chg != 2'b00 |=> ms_irq_o);

  // R9
  eoi_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msi_eoi_i && ms_chg == 2'b00 |=> !ms_irq_o);

  // R10
  flip_flush_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_flip |=> !tx_avail_o && !rx_avail_o);

  // R11
  empty_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_avail_o && !rx_push_i |=> !rx_avail_o);
endmodule

bind uart_fifo_irq uart_fifo_irq_chk #(.DEPTH(DEPTH)) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .fifo_en_i  (fifo_en_i),
  .host_wr_i  (host_wr_i),
  .tx_pop_i   (tx_pop_i),
  .rx_push_i  (rx_push_i),
  .msi_eoi_i  (msi_eoi_i),
  .mode_flip  (mode_flip),
  .tx_cnt     (tx_cnt),
  .rx_cnt     (rx_cnt),
  .to_flag    (to_flag),
  .ms_chg     (ms_chg),
  .tx_avail_o (tx_avail_o),
  .rx_avail_o (rx_avail_o),
  .tx_irq_o   (tx_irq_o),
  .rx_irq_o   (rx_irq_o),
  .ms_irq_o   (ms_irq_o)
);

// File: tb/uart_fifo_irq_tb_top.sv
`timescale 1ns/1ps
module uart_fifo_irq_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       fifo_en_i = 1'b0;
  logic       host_wr_i = 1'b0;
  logic [7:0] host_wdata_i = '0;
  logic       host_rd_i = 1'b0;
  logic [7:0] host_rdata_o;
  logic       rx_avail_o;
  logic       tx_pop_i = 1'b0;
  logic [7:0] tx_data_o;
  logic       tx_avail_o;
  logic       rx_push_i = 1'b0;
  logic [7:0] rx_data_i = '0;
  logic       char_tick_i = 1'b0;
  logic       cts_i = 1'b0;
  logic       dsr_i = 1'b0;
  logic       msi_eoi_i = 1'b0;
  logic       tx_irq_o, rx_irq_o, ms_irq_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  uart_fifo_irq dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .fifo_en_i(fifo_en_i),
    .host_wr_i(host_wr_i), .host_wdata_i(host_wdata_i),
    .host_rd_i(host_rd_i), .host_rdata_o(host_rdata_o), .rx_avail_o(rx_avail_o),
    .tx_pop_i(tx_pop_i), .tx_data_o(tx_data_o), .tx_avail_o(tx_avail_o),
    .rx_push_i(rx_push_i), .rx_data_i(rx_data_i), .char_tick_i(char_tick_i),
    .cts_i(cts_i), .dsr_i(dsr_i), .msi_eoi_i(msi_eoi_i),
    .tx_irq_o(tx_irq_o), .rx_irq_o(rx_irq_o), .ms_irq_o(ms_irq_o)
  );

  function automatic logic [7:0] pat(input int i);
    return 8'((i * 37 + 11) % 256);
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk_i);
    #1;
  endtask

  task automatic wr(input logic [7:0] d);
    host_wr_i = 1'b1; host_wdata_i = d; cyc(); host_wr_i = 1'b0;
  endtask
  task automatic pop();
    tx_pop_i = 1'b1; cyc(); tx_pop_i = 1'b0;
  endtask
  task automatic push(input logic [7:0] d);
    rx_push_i = 1'b1; rx_data_i = d; cyc(); rx_push_i = 1'b0;
  endtask
  task automatic rd();
    host_rd_i = 1'b1; cyc(); host_rd_i = 1'b0;
  endtask
  task automatic tick();
    char_tick_i = 1'b1; cyc(); char_tick_i = 1'b0;
  endtask
  task automatic eoi();
    msi_eoi_i = 1'b1; cyc(); msi_eoi_i = 1'b0;
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    int cnt;
    repeat (3) cyc();
    rst_ni = 1'b1;
    cyc();
    // R1
    chk("R1", "tx_avail", tx_avail_o, 0);
    chk("R1", "rx_avail", rx_avail_o, 0);
    chk("R1", "tx_irq", tx_irq_o, 1);
    chk("R1", "rx_irq", rx_irq_o, 0);
    chk("R1", "ms_irq", ms_irq_o, 0);

    // R4 holding mode transmit
    wr(8'hA5);
    chk("R4", "tx_avail", tx_avail_o, 1);
    chk("R4", "tx_irq occupied", tx_irq_o, 0);
    chk("R4", "tx_data", tx_data_o, 8'hA5);
    wr(8'h3C);
    chk("R4", "second write dropped", tx_data_o, 8'hA5);
    pop();
    chk("R4", "tx_irq empty", tx_irq_o, 1);
    chk("R4", "tx_avail after pop", tx_avail_o, 0);
    pop();
    chk("R11", "pop empty tx", tx_avail_o, 0);

    // R7 holding mode receive
    push(8'h5A);
    chk("R7", "rx_irq valid", rx_irq_o, 1);
    chk("R7", "rdata", host_rdata_o, 8'h5A);
    push(8'h77);
    chk("R7", "second push dropped", host_rdata_o, 8'h5A);
    repeat (4) tick();
    chk("R7", "ticks no effect", rx_irq_o, 1);
    rd();
    chk("R7", "rx_irq after read", rx_irq_o, 0);
    rd();
    chk("R11", "read empty rx", rx_avail_o, 0);

    // switch to queue mode
    fifo_en_i = 1'b1;
    cyc();
    chk("R10", "tx_irq after flip", tx_irq_o, 1);

    // R3 / R2 transmit sweep
    for (int i = 0; i <= 16; i++) begin
      wr(pat(i));
      cnt = (i + 1 > 16) ? 16 : i + 1;
      chk("R3", "tx_irq fill", tx_irq_o, (cnt <= 8) ? 1 : 0);
    end
    for (int i = 0; i < 16; i++) begin
      chk("R2", "tx order", tx_data_o, pat(i));
      pop();
      cnt = 15 - i;
      chk("R3", "tx_irq drain", tx_irq_o, (cnt <= 8) ? 1 : 0);
      chk("R2", "tx_avail drain", tx_avail_o, (cnt != 0) ? 1 : 0);
    end
    pop();
    chk("R11", "pop empty queue", tx_avail_o, 0);

    // R5 / R2 receive sweep
    for (int i = 0; i <= 16; i++) begin
      push(pat(i + 3));
      cnt = (i + 1 > 16) ? 16 : i + 1;
      chk("R5", "rx_irq fill", rx_irq_o, (cnt >= 8) ? 1 : 0);
    end
    for (int i = 0; i < 16; i++) begin
      chk("R2", "rx order", host_rdata_o, pat(i + 3));
      rd();
      cnt = 15 - i;
      chk("R5", "rx_irq drain", rx_irq_o, (cnt >= 8) ? 1 : 0);
    end
    chk("R2", "rx empty after drain", rx_avail_o, 0);

    // R6 idle timeout
    repeat (5) tick();
    chk("R6", "no timeout when empty", rx_irq_o, 0);
    push(8'h01);
    tick(); tick();
    chk("R6", "two ticks", rx_irq_o, 0);
    push(8'h02);
    tick(); tick();
    chk("R6", "reload by push", rx_irq_o, 0);
    tick();
    chk("R6", "third tick", rx_irq_o, 1);
    tick();
    chk("R6", "stays set", rx_irq_o, 1);
    rd();
    chk("R6", "set until empty", rx_irq_o, 1);
    rd();
    chk("R6", "clear on empty", rx_irq_o, 0);
    push(8'h10); push(8'h11); push(8'h12);
    tick(); tick();
    rd();
    tick(); tick();
    chk("R6", "reload by read", rx_irq_o, 0);
    tick();
    chk("R6", "timeout after read", rx_irq_o, 1);
    rd(); rd();
    chk("R6", "cleared after drain", rx_irq_o, 0);

    // R10 flush on mode change
    push(8'h21); push(8'h22); push(8'h23);
    wr(8'h31); wr(8'h32); wr(8'h33);
    tick(); tick();
    fifo_en_i = 1'b0;
    cyc();
    chk("R10", "tx flushed", tx_avail_o, 0);
    chk("R10", "rx flushed", rx_avail_o, 0);
    chk("R10", "tx_irq", tx_irq_o, 1);
    chk("R10", "rx_irq", rx_irq_o, 0);
    fifo_en_i = 1'b1;
    cyc();
    push(8'h40);
    tick(); tick();
    chk("R10", "timeout restarted", rx_irq_o, 0);
    rd();

    // R8 modem edges, both lines, both directions
    for (int k = 0; k < 4; k++) begin
      if (k % 2 == 0) cts_i = ~cts_i; else dsr_i = ~dsr_i;
      cyc();
      chk("R8", "edge+1", ms_irq_o, 0);
      cyc();
      chk("R8", "edge+2", ms_irq_o, 0);
      cyc();
      chk("R8", "edge+3", ms_irq_o, 1);
      cyc();
      chk("R8", "sticky", ms_irq_o, 1);
      eoi();
      chk("R8", "eoi clears", ms_irq_o, 0);
    end

    // R9 edge and eoi in the same cycle
    dsr_i = ~dsr_i;
    repeat (3) cyc();
    chk("R9", "set before collision", ms_irq_o, 1);
    cts_i = ~cts_i;
    cyc(); cyc();
    eoi();
    chk("R9", "set wins over eoi", ms_irq_o, 1);
    eoi();
    chk("R9", "later eoi clears", ms_irq_o, 0);

    summary();
  end
endmodule